// File: doc/BRIEF.md
# Sticky Status and Interrupt Register Bank

The block holds one or more words of event flags. Each flag watches one live condition input. It latches to 1 whenever that input changes level, in either direction. Every flag has a mask bit. A single registered interrupt line is raised while any flag is set and its mask is clear. Software reaches the bank through a plain synchronous strobe interface: a read strobe, a write strobe, an address and write data. Read data is returned one cycle after the read strobe.

The address selects a word index in its upper bits and a register kind in its two low bits. The register kinds are status, mask, live and control. A run-time control bit chooses how flags are cleared. In clear-on-read mode, reading a status word empties it. In write-one-to-clear mode, software writes ones to the flags it wants to drop. The clear logic has no sequencer; the only mode state is the clear-mode register, which holds one of two named values, CLR_BY_READ and CLR_BY_W1. Software moves it in either direction with a single control write.

Top module: `csr_status_irq`

## Requirements
- R1: The control register (kind 3, reachable at every valid word index) holds the clear mode in bit 0. A value of 1 means clear-on-read and 0 means write-one-to-clear. After reset it is 1, and its other bits read as 0.
- R2: In clear-on-read mode, a read of a status word (kind 0) returns its contents and empties that word at the same edge. Reads of the other kinds, and reads of other words, leave the flags unchanged.
- R3: In write-one-to-clear mode, writing to a status word clears each flag whose data bit is 1 and keeps each flag whose data bit is 0. Reads do not clear in this mode. In clear-on-read mode, writes to status words are ignored.
- R4: Any level change of a live input, rising or falling, sets its flag. A live input is compared with its value sampled at the previous clock edge, and the flag is 1 after the next edge. The sampled live value resets to 0.
- R5: If a live change and a clear by read or by write hit the same flag in the same cycle, the flag ends up set.
- R6: A read of kind 2 returns the live inputs as sampled at the last clock edge. Bus writes have no effect on these values.
- R7: A write to kind 1 loads that word's mask. The registered irq output equals the OR over all flags ANDed with the inverse of their mask bits, as that value stood one clock earlier.
- R8: After reset, all flags are 0, all mask bits are 1, irq is 0 and rd_data is 0.
- R9: rd_data is loaded at the clock edge where rd_en is high and holds between reads. A word index at or above the word count reads 0 and ignores writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| live_in | input | NUM_WORDS*WORD_W | Live conditions; word w occupies bits w*WORD_W upward |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| addr | input | ADDR_W | Bits [1:0] select the kind (0 status, 1 mask, 2 live, 3 control); upper bits select the word |
| wr_data | input | WORD_W | Write data |
| rd_data | output | WORD_W | Registered read data |
| irq | output | 1 | Registered interrupt request |

## Verification
A live change presented before edge N shows up as a set flag after edge N. The irq line responds one edge later, at N+1. A read strobe at edge N returns its data and applies any clear at that same edge, so irq drops at N+1. The bench drives every stimulus on a falling edge and samples on later falling edges. It waits exactly one falling edge for flags and read data, and two for irq, so every result is checked at the first half-cycle in which it is due.

// File: rtl/csr_pkg.sv
package csr_pkg;

    typedef enum logic [1:0] {
        REG_STATUS = 2'd0,
        REG_MASK   = 2'd1,
        REG_LIVE   = 2'd2,
        REG_CTRL   = 2'd3
    } reg_kind_e;

    typedef enum logic {
        CLR_BY_W1   = 1'b0,
        CLR_BY_READ = 1'b1
    } clr_mode_e;

endpackage

// File: rtl/csr_live_edge.sv
module csr_live_edge #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] live_in,
    output logic [W-1:0] live_q,
    output logic [W-1:0] edge_o
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) live_q <= '0;
        else        live_q <= live_in;
    end

    // Either direction of change counts as an event.
    assign edge_o = live_in ^ live_q;

endmodule

// File: rtl/csr_status_word.sv
module csr_status_word #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] edge_i,
    input  logic [W-1:0] clr_i,
    input  logic         mask_we,
    input  logic [W-1:0] mask_wd,
    output logic [W-1:0] status_o,
    output logic [W-1:0] mask_o
);

    // Set takes priority over clear so a coincident event survives.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) status_o <= '0;
        else        status_o <= (status_o & ~clr_i) | edge_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       mask_o <= '1;
        else if (mask_we) mask_o <= mask_wd;
    end

endmodule

// File: rtl/csr_irq_merge.sv
module csr_irq_merge #(
    parameter int TOTAL = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [TOTAL-1:0] status_i,
    input  logic [TOTAL-1:0] mask_i,
    output logic             irq_o
);

    logic pending;
    assign pending = |(status_i & ~mask_i);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) irq_o <= 1'b0;
        else        irq_o <= pending;
    end

endmodule

// File: rtl/csr_status_irq.sv
module csr_status_irq #(
    parameter int NUM_WORDS = 2,
    parameter int WORD_W    = 8,
    parameter int IDX_W     = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1,
    parameter int ADDR_W    = IDX_W + 2
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [NUM_WORDS*WORD_W-1:0] live_in,
    input  logic                        rd_en,
    input  logic                        wr_en,
    input  logic [ADDR_W-1:0]           addr,
    input  logic [WORD_W-1:0]           wr_data,
    output logic [WORD_W-1:0]           rd_data,
    output logic                        irq
);
    import csr_pkg::*;

    localparam int TOTAL = NUM_WORDS * WORD_W;

    reg_kind_e         kind;
    logic [IDX_W-1:0]  idx;
    logic              in_range;
    clr_mode_e         mode_q;

    logic [TOTAL-1:0]  status_flat;
    logic [TOTAL-1:0]  mask_flat;
    logic [TOTAL-1:0]  live_flat;
    logic [TOTAL-1:0]  edge_flat;
    logic [WORD_W-1:0] rd_mux;

    assign kind     = reg_kind_e'(addr[1:0]);
    assign idx      = addr[ADDR_W-1:2];
    assign in_range = (32'(idx) < NUM_WORDS);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            mode_q <= CLR_BY_READ;
        else if (wr_en && in_range && kind == REG_CTRL)
            mode_q <= clr_mode_e'(wr_data[0]);
    end

    for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
        logic              sel;
        logic [WORD_W-1:0] clr;

        assign sel = in_range && (idx == IDX_W'(w)) && (kind == REG_STATUS);

        always_comb begin
            clr = '0;
            unique case (mode_q)
                CLR_BY_READ: if (rd_en && sel) clr = '1;
                CLR_BY_W1:   if (wr_en && sel) clr = wr_data;
            endcase
        end

        csr_live_edge #(.W(WORD_W)) u_edge (
            .clk     (clk),
            .rst_n   (rst_n),
            .live_in (live_in[w*WORD_W +: WORD_W]),
            .live_q  (live_flat[w*WORD_W +: WORD_W]),
            .edge_o  (edge_flat[w*WORD_W +: WORD_W])
        );

        csr_status_word #(.W(WORD_W)) u_word (
            .clk      (clk),
            .rst_n    (rst_n),
            .edge_i   (edge_flat[w*WORD_W +: WORD_W]),
            .clr_i    (clr),
            .mask_we  (wr_en && in_range && idx == IDX_W'(w) && kind == REG_MASK),
            .mask_wd  (wr_data),
            .status_o (status_flat[w*WORD_W +: WORD_W]),
            .mask_o   (mask_flat[w*WORD_W +: WORD_W])
        );
    end

    always_comb begin
        rd_mux = '0;
        for (int w = 0; w < NUM_WORDS; w++) begin
            if (in_range && idx == IDX_W'(w)) begin
                unique case (kind)
                    REG_STATUS: rd_mux = status_flat[w*WORD_W +: WORD_W];
                    REG_MASK:   rd_mux = mask_flat[w*WORD_W +: WORD_W];
                    REG_LIVE:   rd_mux = live_flat[w*WORD_W +: WORD_W];
                    REG_CTRL:   rd_mux = WORD_W'(mode_q);
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     rd_data <= '0;
        else if (rd_en) rd_data <= rd_mux;
    end

    csr_irq_merge #(.TOTAL(TOTAL)) u_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .status_i (status_flat),
        .mask_i   (mask_flat),
        .irq_o    (irq)
    );

endmodule

// File: rtl/csr_status_irq_chk.sv
module csr_status_irq_chk #(
    parameter int NUM_WORDS = 2,
    parameter int WORD_W    = 8,
    parameter int ADDR_W    = 3
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic [NUM_WORDS*WORD_W-1:0] live_in,
    input logic                        rd_en,
    input logic                        wr_en,
    input logic [ADDR_W-1:0]           addr,
    input logic                        irq,
    input logic [NUM_WORDS*WORD_W-1:0] status_flat,
    input logic [NUM_WORDS*WORD_W-1:0] mask_flat,
    input logic [NUM_WORDS*WORD_W-1:0] live_flat,
    input logic                        mode_q
);

    // R4: a flag only rises where a live change was seen one edge earlier
    assert_set_only_on_change_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ((status_flat & ~$past(status_flat)) & ~$past(live_in ^ live_flat)) == '0);

    // R5: every seen change leaves its flag set, whatever clear was applied
    assert_set_beats_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(live_in ^ live_flat) & ~status_flat) == '0);

    // R6: the sampled live value depends only on the live inputs
    assert_live_sampled_R6: assert property (@(posedge clk) disable iff (!rst_n)
        live_flat == $past(live_in));

    // R7: irq is the previous cycle's unmasked pending state
    assert_irq_registered_R7: assert property (@(posedge clk) disable iff (!rst_n)
        irq == $past(|(status_flat & ~mask_flat)));

    // R3: with write-one-to-clear selected and no write, no flag falls
    assert_no_fall_without_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_q && !wr_en) |=> ((~status_flat & $past(status_flat)) == '0));

    // R2: a clearing read of word 0 leaves only coincident changes
    assert_read_clears_word0_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q && rd_en && addr == '0) |=>
            status_flat[WORD_W-1:0] == $past(live_in[WORD_W-1:0] ^ live_flat[WORD_W-1:0]));

endmodule

bind csr_status_irq csr_status_irq_chk #(
    .NUM_WORDS (NUM_WORDS),
    .WORD_W    (WORD_W),
    .ADDR_W    (ADDR_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .live_in     (live_in),
    .rd_en       (rd_en),
    .wr_en       (wr_en),
    .addr        (addr),
    .irq         (irq),
    .status_flat (status_flat),
    .mask_flat   (mask_flat),
    .live_flat   (live_flat),
    .mode_q      (mode_q)
);

// File: tb/tb_csr_status_irq.sv
module tb_csr_status_irq;

    localparam int NW = 2;
    localparam int WW = 4;
    localparam int AW = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NW*WW-1:0] live_in = '0;
    logic          rd_en = 1'b0;
    logic          wr_en = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [WW-1:0] wr_data = '0;
    logic [WW-1:0] rd_data;
    logic          irq;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    logic [WW-1:0] live_m [NW];

    csr_status_irq #(.NUM_WORDS(NW), .WORD_W(WW)) dut (
        .clk(clk), .rst_n(rst_n), .live_in(live_in), .rd_en(rd_en),
        .wr_en(wr_en), .addr(addr), .wr_data(wr_data), .rd_data(rd_data), .irq(irq)
    );

    always #10 clk = ~clk;

    task automatic check(input string tag, input logic [WW-1:0] got, input logic [WW-1:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    function automatic logic [AW-1:0] a(input int w, input int k);
        return AW'((w << 2) | k);
    endfunction

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic rd(input logic [AW-1:0] ad, output logic [WW-1:0] d);
        rd_en = 1'b1; addr = ad;
        tick();
        rd_en = 1'b0;
        d = rd_data;
    endtask

    task automatic wr(input logic [AW-1:0] ad, input logic [WW-1:0] d);
        wr_en = 1'b1; addr = ad; wr_data = d;
        tick();
        wr_en = 1'b0;
    endtask

    task automatic toggle(input int w, input logic [WW-1:0] t);
        live_m[w] = live_m[w] ^ t;
        live_in[w*WW +: WW] = live_m[w];
        tick();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [WW-1:0] d;
        for (int w = 0; w < NW; w++) live_m[w] = '0;
        tick(); tick();
        rst_n = 1'b1;
        tick();

        // R8 reset state, R1 control reset value
        check("R8 irq", WW'(irq), '0);
        check("R8 rd_data", rd_data, '0);
        for (int w = 0; w < NW; w++) begin
            rd(a(w, 0), d); check("R8 status", d, '0);
            rd(a(w, 1), d); check("R8 mask", d, 4'hF);
            rd(a(w, 3), d); check("R1 ctrl reset", d, 4'h1);
        end

        // R4/R2/R6: sweep every live value per word, rising and falling edges
        for (int w = 0; w < NW; w++) begin
            for (int v = 0; v < 16; v++) begin
                logic [WW-1:0] old;
                old = live_m[w];
                toggle(w, old ^ WW'(v));
                rd(a(w, 2), d); check("R6 live read", d, WW'(v));
                rd(a(w, 0), d); check("R4 flags after change", d, old ^ WW'(v));
                rd(a(w, 0), d); check("R2 cleared by read", d, '0);
            end
        end

        // R7: every mask against every flag pattern
        for (int w = 0; w < NW; w++) begin
            for (int m = 0; m < 16; m++) begin
                for (int s = 0; s < 16; s++) begin
                    wr(a(w, 1), WW'(m));
                    toggle(w, WW'(s));
                    tick();
                    check("R7 irq", WW'(irq), WW'(|(WW'(s) & ~WW'(m))));
                    rd(a(w, 0), d); check("R2 read value", d, WW'(s));
                    tick();
                    check("R7 irq after clear", WW'(irq), '0);
                end
            end
            wr(a(w, 1), 4'hF);
        end
        rd(a(0, 1), d); check("R7 mask readback", d, 4'hF);

        // R3: writes to status ignored in clear-on-read mode
        toggle(0, 4'h6);
        wr(a(0, 0), 4'hF);
        rd(a(0, 2), d); check("R2 live read keeps flags", d, live_m[0]);
        rd(a(0, 0), d); check("R3 write ignored in read mode", d, 4'h6);

        // R6: writes to the live address have no effect
        wr(a(1, 2), ~live_m[1]);
        rd(a(1, 2), d); check("R6 live unaffected by write", d, live_m[1]);

        // R1/R3: switch to write-one-to-clear and sweep the clear data
        wr(a(0, 3), 4'h0);
        rd(a(1, 3), d); check("R1 ctrl w1c", d, 4'h0);
        for (int c = 0; c < 16; c++) begin
            toggle(0, 4'hF);
            wr(a(0, 0), 4'hF);
            toggle(0, 4'hF);
            wr(a(0, 0), WW'(c));
            rd(a(0, 0), d); check("R3 w1c result", d, 4'hF & ~WW'(c));
            rd(a(0, 0), d); check("R3 read does not clear", d, 4'hF & ~WW'(c));
            wr(a(0, 0), 4'hF);
        end

        // R3: clearing word 0 leaves word 1
        toggle(1, 4'h9);
        wr(a(0, 0), 4'hF);
        rd(a(1, 0), d); check("R3 other word kept", d, 4'h9);
        wr(a(1, 0), 4'hF);

        // R5: coincident write clear and change in w1c mode
        toggle(0, 4'hF);
        live_m[0] = live_m[0] ^ 4'h1;
        live_in[0 +: WW] = live_m[0];
        wr(a(0, 0), 4'hF);
        rd(a(0, 0), d); check("R5 set beats write clear", d, 4'h1);
        wr(a(0, 0), 4'hF);

        // R5: coincident read clear and change in clear-on-read mode
        wr(a(0, 3), 4'h1);
        toggle(0, 4'hC);
        live_m[0] = live_m[0] ^ 4'h2;
        live_in[0 +: WW] = live_m[0];
        rd(a(0, 0), d); check("R5 read returns old flags", d, 4'hC);
        rd(a(0, 0), d); check("R5 set beats read clear", d, 4'h2);

        // R9: out-of-range index and rd_data hold
        rd(a(1, 1), d); check("R9 mask read", d, 4'hF);
        tick(); tick();
        check("R9 rd_data holds", rd_data, 4'hF);
        if (NW < 2 ** (AW - 2)) begin
            rd(AW'(NW << 2), d); check("R9 out of range", d, '0);
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule